// File: doc/BRIEF.md
# Exception Entry Vector Generator

This unit computes everything a processor core needs at the moment it takes an exception. A single-cycle request carries the exception kind, the program counter of the faulting instruction, a flag that says the instruction sat in a branch delay slot, a flag that marks a TLB miss with no matching entry, and a snapshot of the status bits. These are the exception level, the error level, the boot-vector select and the interrupt-vector select, together with the programmable exception base. The unit returns the handler address, the 5-bit cause code, the saved resume address and the branch-delay bit. It also returns the updated exception level, error level and boot-vector bits, and a flag that privilege is now kernel.

Interrupts can be dispatched in vectored mode. The lowest-numbered pending line selects a slot, and a programmable spacing field sets the slot size. Non-maskable interrupts and soft resets take a separate path that records the resume address in an error-level register and jumps to the fixed error vector. Results are registered, and a one-cycle done strobe marks the cycle in which they are valid.

Top module: `excvec_gen`

## Requirements
- R1: Kind encoding on `req_kind` is 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address error load, 5 address error store, 6 syscall, 7 break, 8 reserved instruction, 9 coprocessor unusable, 10 overflow and 11 trap. The cause codes reported for these kinds are, in the same order, 0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12 and 13.
- R2: When `st_bev` is 1, the handler address of kinds 0 to 11 is 0xBFC00200 plus the offset. The default offset is 0x180.
- R3: When `st_bev` is 0, the handler base is `ebase` with bits 9:0 forced to zero.
- R4: Kinds 2 and 3 with `req_refill` 1 and `st_exl` 0 use offset 0x000. With `st_exl` 1, or with `req_refill` 0, they use 0x180.
- R5: An interrupt (kind 0) with `vec_en` 0 uses offset 0x200 when `st_iv` is 1 and 0x180 when it is 0.
- R6: An interrupt with `vec_en` 1 uses offset 0x200 + n × (`vec_spacing` << 5). Here n is the index of the lowest set bit of `irq_pend`, and n is 8 when no bit is set.
- R7: For kinds 0 to 11 with `st_exl` 0, `epc` becomes `req_pc`, minus 4 when `req_in_slot` is 1, and `bd_out` becomes `req_in_slot`. For every kind 0 to 11, `exl_out` becomes 1, `erl_out` copies `st_erl` and `bev_out` copies `st_bev`.
- R8: For kinds 0 to 11 with `st_exl` 1, `epc` and `bd_out` keep their previous values, while the handler address and cause code still update.
- R9: Kind 12 (NMI) and kind 13 (soft reset) load `err_epc` with `req_pc`, minus 4 when in a slot. They set `erl_out` and `bev_out` to 1, give handler 0xBFC00000, and leave `epc`, `bd_out`, `cause_code` and `exl_out` unchanged.
- R10: A request with a legal kind (0 to 13) sampled on a rising edge updates the outputs on that edge and raises `done` for exactly the following cycle, with `kernel_out` 1. Kinds 14 and 15 are ignored: no `done`, and no output changes.
- R11: After synchronous reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Single-cycle request pulse |
| req_kind | input | 4 | Exception kind (R1 encoding, 12 NMI, 13 soft reset) |
| req_pc | input | ADDR_W | PC of the faulting instruction |
| req_in_slot | input | 1 | Faulting instruction was in a delay slot |
| req_refill | input | 1 | TLB access found no matching entry |
| st_exl | input | 1 | Current exception level |
| st_erl | input | 1 | Current error level |
| st_bev | input | 1 | Boot exception vectors selected |
| st_iv | input | 1 | Interrupts use the dedicated offset |
| ebase | input | ADDR_W | Exception base register |
| vec_en | input | 1 | Vectored interrupt dispatch enabled |
| vec_spacing | input | SPW | Vector spacing field |
| irq_pend | input | NPEND | Pending interrupt lines |
| handler_pc | output | ADDR_W | Handler entry address |
| cause_code | output | 5 | Exception cause code |
| epc | output | ADDR_W | Saved resume address |
| err_epc | output | ADDR_W | Saved resume address for error-level entries |
| bd_out | output | 1 | Branch-delay bit |
| exl_out | output | 1 | Updated exception level |
| erl_out | output | 1 | Updated error level |
| bev_out | output | 1 | Updated boot-vector bit |
| kernel_out | output | 1 | Privilege is kernel after the entry |
| done | output | 1 | Results valid this cycle |

## Verification
The bench builds the block with its defaults: 32-bit addresses, eight pending lines and a 5-bit spacing field. With eight lines, both an empty pending set (slot 8) and the highest line can be reached. The 5-bit field allows the largest spacing of 31 × 32 bytes, which pushes the vectored offset past 0x2000 and beyond the low bits of the base. Requests alternate the exception level so that both the capture and the hold of the resume address occur behind a matching handler address.

// File: rtl/excvec_pkg.sv
// Shared kinds and constants for the exception entry vector generator.
// Assumes 32-bit style vector constants; wider addresses sign-extend them.
package excvec_pkg;
    localparam int KIND_W  = 4;
    localparam int CAUSE_W = 5;

    typedef enum logic [KIND_W-1:0] {
        EK_INT  = 4'd0,
        EK_TMOD = 4'd1,
        EK_TLD  = 4'd2,
        EK_TST  = 4'd3,
        EK_ADL  = 4'd4,
        EK_ADS  = 4'd5,
        EK_SYS  = 4'd6,
        EK_BRK  = 4'd7,
        EK_RSV  = 4'd8,
        EK_CPU  = 4'd9,
        EK_OVF  = 4'd10,
        EK_TRP  = 4'd11,
        EK_NMI  = 4'd12,
        EK_SRST = 4'd13
    } exc_kind_e;

    localparam logic [31:0] BOOT_BASE  = 32'hBFC0_0200;
    localparam logic [31:0] ERR_VECTOR = 32'hBFC0_0000;
    localparam logic [31:0] OFF_GEN    = 32'h0000_0180;
    localparam logic [31:0] OFF_IRQ    = 32'h0000_0200;
    localparam logic [31:0] OFF_REFILL = 32'h0000_0000;
    localparam int          SLOT_SHIFT = 5;
    localparam int          BASE_LOW   = 10;
endpackage

// File: rtl/excvec_decode.sv
// Decodes an exception kind into its cause code and class flags.
// Assumes kinds 14 and 15 are unused and flags them as illegal.
module excvec_decode
    import excvec_pkg::*;
(
    input  logic [KIND_W-1:0]  kind,
    output logic [CAUSE_W-1:0] cause,
    output logic               legal,
    output logic               is_irq,
    output logic               is_tlb_rw,
    output logic               is_err
);
    // Map each kind to its cause code and class.
    always_comb begin
        cause     = '0;
        legal     = 1'b1;
        is_irq    = 1'b0;
        is_tlb_rw = 1'b0;
        is_err    = 1'b0;
        case (kind)
            EK_INT:  begin cause = 5'd0; is_irq = 1'b1; end
            EK_TMOD: cause = 5'd1;
            EK_TLD:  begin cause = 5'd2; is_tlb_rw = 1'b1; end
            EK_TST:  begin cause = 5'd3; is_tlb_rw = 1'b1; end
            EK_ADL:  cause = 5'd4;
            EK_ADS:  cause = 5'd5;
            EK_SYS:  cause = 5'd8;
            EK_BRK:  cause = 5'd9;
            EK_RSV:  cause = 5'd10;
            EK_CPU:  cause = 5'd11;
            EK_OVF:  cause = 5'd12;
            EK_TRP:  cause = 5'd13;
            EK_NMI, EK_SRST: is_err = 1'b1;
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/excvec_offset.sv
// Selects the handler offset: refill, general, interrupt or vectored slot.
// Assumes the lowest-numbered pending line wins; no line pending gives slot NPEND.
module excvec_offset
    import excvec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NPEND  = 8,
    parameter int SPW    = 5
) (
    input  logic              is_irq,
    input  logic              is_tlb_rw,
    input  logic              refill,
    input  logic              exl,
    input  logic              iv,
    input  logic              vec_en,
    input  logic [SPW-1:0]    spacing,
    input  logic [NPEND-1:0]  pend,
    output logic [ADDR_W-1:0] offset
);
    localparam int IDX_W = $clog2(NPEND + 1);

    logic [IDX_W-1:0]  slot_idx;
    logic [ADDR_W-1:0] slot_size;
    logic [ADDR_W-1:0] vec_off;

    // Priority-encode the pending lines, lowest index first.
    always_comb begin
        slot_idx = IDX_W'(NPEND);
        for (int i = NPEND - 1; i >= 0; i--) begin
            if (pend[i]) slot_idx = IDX_W'(i);
        end
    end

    // Scale the slot index by the programmed spacing.
    always_comb begin
        slot_size = ADDR_W'(spacing) << SLOT_SHIFT;
        vec_off   = ADDR_W'(OFF_IRQ) + ADDR_W'(slot_idx) * slot_size;
    end

    // Choose the offset for this kind and state.
    always_comb begin
        if (is_irq) begin
            if (vec_en)  offset = vec_off;
            else if (iv) offset = ADDR_W'(OFF_IRQ);
            else         offset = ADDR_W'(OFF_GEN);
        end else if (is_tlb_rw && refill && !exl) begin
            offset = ADDR_W'(OFF_REFILL);
        end else begin
            offset = ADDR_W'(OFF_GEN);
        end
    end
endmodule

// File: rtl/excvec_target.sv
// Forms the handler address from the base and offset, and the resume address.
// Assumes instructions in the delay slot resume at the branch, 4 bytes earlier.
module excvec_target
    import excvec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              bev,
    input  logic [ADDR_W-1:0] ebase,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] pc,
    input  logic              in_slot,
    output logic [ADDR_W-1:0] handler,
    output logic [ADDR_W-1:0] resume
);
    logic [ADDR_W-1:0] base;

    // Pick the boot base or the aligned programmable base.
    always_comb begin
        if (bev) base = ADDR_W'($signed(BOOT_BASE));
        else     base = {ebase[ADDR_W-1:BASE_LOW], {BASE_LOW{1'b0}}};
        handler = base + offset;
    end

    // Step back over the branch when the fault sat in a delay slot.
    always_comb begin
        resume = in_slot ? (pc - ADDR_W'(4)) : pc;
    end
endmodule

// File: rtl/excvec_gen.sv
// Top of the exception entry vector generator. Samples a one-cycle request,
// registers all results on the same edge and pulses done for one cycle.
// Assumes the status inputs are stable with the request.
module excvec_gen
    import excvec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NPEND  = 8,
    parameter int SPW    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [KIND_W-1:0]  req_kind,
    input  logic [ADDR_W-1:0]  req_pc,
    input  logic               req_in_slot,
    input  logic               req_refill,
    input  logic               st_exl,
    input  logic               st_erl,
    input  logic               st_bev,
    input  logic               st_iv,
    input  logic [ADDR_W-1:0]  ebase,
    input  logic               vec_en,
    input  logic [SPW-1:0]     vec_spacing,
    input  logic [NPEND-1:0]   irq_pend,
    output logic [ADDR_W-1:0]  handler_pc,
    output logic [CAUSE_W-1:0] cause_code,
    output logic [ADDR_W-1:0]  epc,
    output logic [ADDR_W-1:0]  err_epc,
    output logic               bd_out,
    output logic               exl_out,
    output logic               erl_out,
    output logic               bev_out,
    output logic               kernel_out,
    output logic               done
);
    logic [CAUSE_W-1:0] cause_d;
    logic               legal;
    logic               is_irq;
    logic               is_tlb_rw;
    logic               is_err;
    logic [ADDR_W-1:0]  offset;
    logic [ADDR_W-1:0]  handler_d;
    logic [ADDR_W-1:0]  resume_d;
    logic               take;

    excvec_decode u_decode (
        .kind      (req_kind),
        .cause     (cause_d),
        .legal     (legal),
        .is_irq    (is_irq),
        .is_tlb_rw (is_tlb_rw),
        .is_err    (is_err)
    );

    excvec_offset #(.ADDR_W(ADDR_W), .NPEND(NPEND), .SPW(SPW)) u_offset (
        .is_irq    (is_irq),
        .is_tlb_rw (is_tlb_rw),
        .refill    (req_refill),
        .exl       (st_exl),
        .iv        (st_iv),
        .vec_en    (vec_en),
        .spacing   (vec_spacing),
        .pend      (irq_pend),
        .offset    (offset)
    );

    excvec_target #(.ADDR_W(ADDR_W)) u_target (
        .bev     (st_bev),
        .ebase   (ebase),
        .offset  (offset),
        .pc      (req_pc),
        .in_slot (req_in_slot),
        .handler (handler_d),
        .resume  (resume_d)
    );

    assign take = req_valid && legal;

    // Register results of an accepted request and strobe done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_pc <= '0;
            cause_code <= '0;
            epc        <= '0;
            err_epc    <= '0;
            bd_out     <= 1'b0;
            exl_out    <= 1'b0;
            erl_out    <= 1'b0;
            bev_out    <= 1'b0;
            kernel_out <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= take;
            if (take) begin
                kernel_out <= 1'b1;
                if (is_err) begin
                    err_epc    <= resume_d;
                    erl_out    <= 1'b1;
                    bev_out    <= 1'b1;
                    handler_pc <= ADDR_W'($signed(ERR_VECTOR));
                end else begin
                    handler_pc <= handler_d;
                    cause_code <= cause_d;
                    exl_out    <= 1'b1;
                    erl_out    <= st_erl;
                    bev_out    <= st_bev;
                    if (!st_exl) begin
                        epc    <= resume_d;
                        bd_out <= req_in_slot;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/excvec_chk.sv
// Property checker for the exception entry vector generator, bound to the top.
// Assumes the kind encoding of excvec_pkg.
module excvec_chk
    import excvec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [KIND_W-1:0] req_kind,
    input logic              st_exl,
    input logic              st_bev,
    input logic [ADDR_W-1:0] handler_pc,
    input logic [ADDR_W-1:0] epc,
    input logic              bd_out,
    input logic              exl_out,
    input logic              erl_out,
    input logic              bev_out,
    input logic              kernel_out,
    input logic              done
);
    assert_done_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid));

    assert_legal_gets_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind <= 4'd13) |=> (done && kernel_out));

    assert_epc_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(st_exl)) |-> ($stable(epc) && $stable(bd_out)));

    assert_exl_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(req_kind) < 4'd12) |-> exl_out);

    assert_err_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(req_kind) >= 4'd12)
        |-> (handler_pc == ADDR_W'($signed(ERR_VECTOR)) && erl_out && bev_out));

    assert_boot_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(req_kind) < 4'd12 && $past(st_bev))
        |-> (handler_pc >= ADDR_W'($signed(BOOT_BASE))));
endmodule

bind excvec_gen excvec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .st_exl     (st_exl),
    .st_bev     (st_bev),
    .handler_pc (handler_pc),
    .epc        (epc),
    .bd_out     (bd_out),
    .exl_out    (exl_out),
    .erl_out    (erl_out),
    .bev_out    (bev_out),
    .kernel_out (kernel_out),
    .done       (done)
);

// File: tb/excvec_gen_bench.sv
`timescale 1ns/1ps
module excvec_gen_bench;
    localparam int AW = 32;
    localparam int NP = 8;
    localparam int SW = 5;

    typedef struct {
        logic [31:0] hpc;
        logic [4:0]  cause;
        logic [31:0] epc;
        logic [31:0] eepc;
        logic        bd;
        logic        exl;
        logic        erl;
        logic        bev;
        logic        kern;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [3:0] req_kind = '0;
    logic [AW-1:0] req_pc = '0;
    logic req_in_slot = 1'b0, req_refill = 1'b0;
    logic st_exl = 1'b0, st_erl = 1'b0, st_bev = 1'b0, st_iv = 1'b0;
    logic [AW-1:0] ebase = '0;
    logic vec_en = 1'b0;
    logic [SW-1:0] vec_spacing = '0;
    logic [NP-1:0] irq_pend = '0;
    logic [AW-1:0] handler_pc, epc, err_epc;
    logic [4:0] cause_code;
    logic bd_out, exl_out, erl_out, bev_out, kernel_out, done;

    int checks = 0;
    int failures = 0;
    exp_t q[$];
    exp_t m;

    always #5 clk = ~clk;

    excvec_gen #(.ADDR_W(AW), .NPEND(NP), .SPW(SW)) u_excvec_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_pc(req_pc), .req_in_slot(req_in_slot), .req_refill(req_refill),
        .st_exl(st_exl), .st_erl(st_erl), .st_bev(st_bev), .st_iv(st_iv),
        .ebase(ebase), .vec_en(vec_en), .vec_spacing(vec_spacing), .irq_pend(irq_pend),
        .handler_pc(handler_pc), .cause_code(cause_code), .epc(epc), .err_epc(err_epc),
        .bd_out(bd_out), .exl_out(exl_out), .erl_out(erl_out), .bev_out(bev_out),
        .kernel_out(kernel_out), .done(done)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(exp_t e);
        chk(e.tag, "handler_pc", handler_pc, e.hpc);
        chk(e.tag, "cause_code", 32'(cause_code), 32'(e.cause));
        chk(e.tag, "epc", epc, e.epc);
        chk(e.tag, "err_epc", err_epc, e.eepc);
        chk(e.tag, "bd_out", 32'(bd_out), 32'(e.bd));
        chk(e.tag, "exl_out", 32'(exl_out), 32'(e.exl));
        chk(e.tag, "erl_out", 32'(erl_out), 32'(e.erl));
        chk(e.tag, "bev_out", 32'(bev_out), 32'(e.bev));
        chk(e.tag, "kernel_out", 32'(kernel_out), 32'(e.kern));
    endtask

    // Driver: apply one request and push the model's expected outputs.
    task automatic take(input logic [3:0] kind, input logic [31:0] pc, input logic slot,
                        input logic refill, input logic exl, input logic bev, input logic iv,
                        input logic erl, input logic ven, input logic [SW-1:0] sp,
                        input logic [NP-1:0] pend, input logic [31:0] eb, input string tag);
        logic [31:0] off, base;
        int n;
        logic [4:0] codes [12];
        codes = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13};
        @(negedge clk);
        req_kind = kind; req_pc = pc; req_in_slot = slot; req_refill = refill;
        st_exl = exl; st_bev = bev; st_iv = iv; st_erl = erl; vec_en = ven;
        vec_spacing = sp; irq_pend = pend; ebase = eb; req_valid = 1'b1;
        if (kind <= 4'd13) begin
            m.kern = 1'b1;
            if (kind >= 4'd12) begin
                m.eepc = slot ? pc - 32'd4 : pc;
                m.erl = 1'b1; m.bev = 1'b1; m.hpc = 32'hBFC00000;
            end else begin
                if (kind == 4'd0) begin
                    if (ven) begin
                        n = NP;
                        for (int i = 0; i < NP; i++) if (pend[i] && n == NP) n = i;
                        off = 32'h200 + 32'(n) * (32'(sp) * 32);
                    end else off = iv ? 32'h200 : 32'h180;
                end else if ((kind == 4'd2 || kind == 4'd3) && refill && !exl) off = 32'h0;
                else off = 32'h180;
                base = bev ? 32'hBFC00200 : (eb & ~32'h3FF);
                m.hpc = base + off;
                m.cause = codes[kind];
                if (!exl) begin
                    m.epc = slot ? pc - 32'd4 : pc;
                    m.bd = slot;
                end
                m.exl = 1'b1; m.erl = erl; m.bev = bev;
            end
            m.tag = tag;
            q.push_back(m);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: each done cycle pops and compares one expected item.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R10 done without request actual=1 expected=0");
                end else compare_all(q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m = '{hpc:0, cause:0, epc:0, eepc:0, bd:0, exl:0, erl:0, bev:0, kern:0, tag:"R11"};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all(m);                                   // R11 reset state
        chk("R11", "done", 32'(done), 32'd0);

        // R1 R2 R7: syscall on boot vectors, not in slot
        take(4'd6, 32'h0040_1000, 0, 0, 0, 1, 0, 0, 0, 0, 0, 32'h0, "R1_R2_R7");
        // R1 R3: every ordinary kind on a programmed base, EXL alternating
        for (int k = 0; k < 12; k++)
            take(4'(k), 32'h0040_2000 + 32'(k * 16), k[0], 0, k[1], 0, 0, 0, 0, 0, 0,
                 32'h8000_1234, "R1_R3_R8");
        // R4: refill with EXL clear, then with EXL set, then a non-refill miss
        take(4'd2, 32'h0000_3000, 1, 1, 0, 0, 0, 0, 0, 0, 0, 32'h8000_0000, "R4_R7");
        take(4'd3, 32'h0000_3100, 0, 1, 1, 0, 0, 0, 0, 0, 0, 32'h8000_0000, "R4_R8");
        take(4'd3, 32'h0000_3200, 0, 0, 0, 1, 0, 0, 0, 0, 0, 32'h0, "R4");
        // R5: interrupt with and without the dedicated offset
        take(4'd0, 32'h0000_4000, 0, 0, 0, 1, 1, 0, 0, 0, 8'h01, 32'h0, "R5");
        take(4'd0, 32'h0000_4004, 0, 0, 0, 0, 0, 1, 0, 0, 8'h01, 32'h9000_0000, "R5");
        // R6: vectored dispatch, several pending patterns and spacings
        take(4'd0, 32'h0000_5000, 0, 0, 0, 0, 1, 0, 1, 5'd3, 8'b0010_1000, 32'h8000_0000, "R6");
        take(4'd0, 32'h0000_5004, 0, 0, 0, 0, 0, 0, 1, 5'd31, 8'h00, 32'h8000_0000, "R6");
        take(4'd0, 32'h0000_5008, 0, 0, 1, 1, 0, 0, 1, 5'd1, 8'h80, 32'h0, "R6");
        take(4'd0, 32'h0000_500C, 1, 0, 0, 0, 0, 0, 1, 5'd0, 8'hFF, 32'h8000_0400, "R6_R7");
        // R9: NMI in a delay slot, soft reset with EXL set
        take(4'd12, 32'h0000_6008, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R9");
        take(4'd13, 32'h0000_6100, 0, 0, 1, 0, 0, 0, 0, 0, 0, 32'h0, "R9");
        // R8 after R9: ordinary entry with EXL set keeps EPC
        take(4'd10, 32'h0000_7000, 1, 0, 1, 1, 0, 1, 0, 0, 0, 32'h0, "R8");
        // R10: unused kinds are ignored
        take(4'd14, 32'h0000_8000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R10");
        take(4'd15, 32'h0000_8004, 0, 0, 0, 1, 0, 0, 0, 0, 0, 32'h0, "R10");
        repeat (2) @(negedge clk);
        m.tag = "R10";
        compare_all(m);
        chk("R10", "pending items", 32'(q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule